// File: doc/BRIEF.md
# DMA Command-Queue Register Model

This block is a memory-mapped register set that behaves, from the host's side, like the command queue of a DMA engine. It moves no data. Software programs a queue base address, an end pointer and a write pointer. Every write to the write pointer counts as a transfer that finishes at once. The block copies the new write pointer into the read pointer, so the queue looks drained. It then sets two completion flags in the status register and, if enabled, raises a level interrupt. The interrupt stays high until software clears it through the status register.

One mechanism exists so that software can move the queue pointers without a completion being reported. Writing a fixed magic value to the read pointer arms a one-shot flag. The next write-pointer update then mirrors the pointer as usual but reports nothing.

The window holds 31 word registers, at byte offsets 0x00 to 0x78. The two low address bits are ignored. Reads have no wait states.

Top module: `cmdq_reg_model`

## Requirements
- R1: After reset every register reads 0, except the status register at 0x3C, which reads 0xF8000000. The irq output is 0 and the one-shot flag is cleared.
- R2: A write at byte offset 0x7C or above changes no register and no output. A read there returns 0. Address bits [1:0] are ignored for both reads and writes.
- R3: Writes to the end pointer (0x18) and to the write pointer (0x1C) store the data ANDed with PTR_WMASK (default 0x03FFFFF8).
- R4: A write to the write pointer also loads the same masked value into the read pointer (0x20).
- R5: A write to the read pointer never changes its stored value. Writing the value RP_MAGIC (default 0xEE882266) arms the one-shot flag. Any other value leaves the flag as it was.
- R6: A write-pointer update while the flag is armed clears the flag and leaves status and irq unchanged. The following write-pointer update completes normally.
- R7: A write-pointer update while the flag is not armed sets status bits 16 and 17. Those are the completion bits, mask 0x00030000.
- R8: A completing write-pointer update drives irq high from the next clock edge, provided interrupt control (0x38) has bit 16 or bit 17 set. irq then stays high until it is cleared as R10 describes.
- R9: Writes to interrupt control (0x38) store the data ANDed with CTRL_WMASK (default 0x017003FF).
- R10: A status write whose data has bit 16 or bit 17 set clears both completion bits and drops irq at the next edge. A status write without either bit has no effect.
- R11: Writes to any other in-range offset, the base address at 0x14 included, store all 32 bits unchanged.
- R12: rdata shows the addressed register in the same cycle as rd_en. While rd_en is low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Byte address shared by reads and writes |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read enable |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with CTRL_WMASK = 0x017303FF. The default mask drops bits 16 and 17, so with it the completion-enable bits could never be stored and irq could never rise. The wider mask brings the interrupt path within reach while leaving the masking rule testable. All other parameters keep their defaults, so the pointer mask and the magic constant are checked at their default values. The bench writes every in-range word twice, with misaligned low address bits, and checks all 31 registers and irq after each write. It also sweeps every out-of-range byte address.

// File: rtl/cmdq_model_pkg.sv
package cmdq_model_pkg;

  localparam int unsigned REG_W = 32;

  // Word indices of the registers with special behaviour (byte offset / 4).
  localparam int unsigned W_BASE = 5;   // 0x14
  localparam int unsigned W_ENDP = 6;   // 0x18
  localparam int unsigned W_WRP  = 7;   // 0x1C
  localparam int unsigned W_RDP  = 8;   // 0x20
  localparam int unsigned W_CTRL = 14;  // 0x38
  localparam int unsigned W_STAT = 15;  // 0x3C

  // Mask applied when word w is stored by an ordinary write.
  function automatic logic [REG_W-1:0] store_mask(input int unsigned w,
                                                  input logic [REG_W-1:0] ptr_m,
                                                  input logic [REG_W-1:0] ctrl_m);
    if (w == W_ENDP || w == W_WRP) return ptr_m;
    if (w == W_CTRL)               return ctrl_m;
    return '1;
  endfunction

  // True when any completion bit is present in v.
  function automatic logic has_cmpl(input logic [REG_W-1:0] v,
                                    input logic [REG_W-1:0] cmpl_m);
    return |(v & cmpl_m);
  endfunction

endpackage

// File: rtl/cmdq_addr_decode.sv
module cmdq_addr_decode
  import cmdq_model_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NWORDS = 31,
  localparam int unsigned IDX_W  = $clog2(NWORDS),
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              in_range,
  output logic [IDX_W-1:0]  widx,
  output logic              wr_store,
  output logic              wr_wrp,
  output logic              wr_rdp,
  output logic              wr_stat
);

  logic [WORD_W-1:0] word;
  logic              wr_ok;

  assign word     = addr[ADDR_W-1:2];
  assign in_range = (int'(word) < NWORDS);
  assign widx     = word[IDX_W-1:0];
  assign wr_ok    = wr_en && in_range;

  assign wr_wrp   = wr_ok && (int'(widx) == W_WRP);
  assign wr_rdp   = wr_ok && (int'(widx) == W_RDP);
  assign wr_stat  = wr_ok && (int'(widx) == W_STAT);
  assign wr_store = wr_ok && !wr_rdp && !wr_stat;

  always_comb begin
    if (!in_range) begin
      p_oor_quiet_r2: assert (!(wr_store || wr_wrp || wr_rdp || wr_stat))
        else $error("p_oor_quiet_r2: strobe for out-of-range address");
    end
  end

endmodule

// File: rtl/cmdq_event_unit.sv
module cmdq_event_unit
  import cmdq_model_pkg::*;
#(
  parameter logic [REG_W-1:0] CMPL_MASK  = 32'h0003_0000,
  parameter logic [REG_W-1:0] STAT_RESET = 32'hF800_0000,
  parameter logic [REG_W-1:0] RP_MAGIC   = 32'hEE88_2266
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_wrp,
  input  logic             wr_rdp,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq_q,
  output logic             arm_q,
  output logic             complete_evt,
  output logic             suppress_evt,
  output logic             clear_evt
);

  logic magic_evt;
  logic irq_en;

  assign complete_evt = wr_wrp && !arm_q;
  assign suppress_evt = wr_wrp && arm_q;
  assign clear_evt    = wr_stat && has_cmpl(wdata, CMPL_MASK);
  assign magic_evt    = wr_rdp && (wdata == RP_MAGIC);
  assign irq_en       = has_cmpl(ctrl_q, CMPL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      stat_q <= STAT_RESET;
      irq_q  <= 1'b0;
    end else begin
      if (suppress_evt)   arm_q <= 1'b0;
      else if (magic_evt) arm_q <= 1'b1;

      if (complete_evt)   stat_q <= stat_q | CMPL_MASK;
      else if (clear_evt) stat_q <= stat_q & ~CMPL_MASK;

      if (complete_evt && irq_en) irq_q <= 1'b1;
      else if (clear_evt)         irq_q <= 1'b0;
    end
  end

  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    magic_evt |=> arm_q)
    else $error("p_arm_r5");

  p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_evt |=> (!arm_q && stat_q == $past(stat_q) && irq_q == $past(irq_q)))
    else $error("p_suppress_r6");

  p_cmpl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt |=> ((stat_q & CMPL_MASK) == CMPL_MASK))
    else $error("p_cmpl_set_r7");

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_evt && irq_en) |=> irq_q)
    else $error("p_irq_rise_r8");

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_stat) |=> irq_q)
    else $error("p_irq_hold_r8");

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (!irq_q && (stat_q & CMPL_MASK) == '0))
    else $error("p_clear_r10");

endmodule

// File: rtl/cmdq_reg_model.sv
module cmdq_reg_model
  import cmdq_model_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 8,
  parameter int unsigned      WIN_BYTES  = 'h7C,
  parameter logic [REG_W-1:0] PTR_WMASK  = 32'h03FF_FFF8,
  parameter logic [REG_W-1:0] CTRL_WMASK = 32'h0170_03FF,
  parameter logic [REG_W-1:0] CMPL_MASK  = 32'h0003_0000,
  parameter logic [REG_W-1:0] STAT_RESET = 32'hF800_0000,
  parameter logic [REG_W-1:0] RP_MAGIC   = 32'hEE88_2266
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);

  localparam int unsigned NWORDS = WIN_BYTES / 4;
  localparam int unsigned IDX_W  = $clog2(NWORDS);

  logic             in_range;
  logic [IDX_W-1:0] widx;
  logic             wr_store, wr_wrp, wr_rdp, wr_stat;
  logic [REG_W-1:0] stat_q;
  logic             arm_q, complete_evt, suppress_evt, clear_evt;
  logic [NWORDS-1:0][REG_W-1:0] regs;

  cmdq_addr_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .in_range (in_range),
    .widx     (widx),
    .wr_store (wr_store),
    .wr_wrp   (wr_wrp),
    .wr_rdp   (wr_rdp),
    .wr_stat  (wr_stat)
  );

  cmdq_event_unit #(
    .CMPL_MASK (CMPL_MASK),
    .STAT_RESET(STAT_RESET),
    .RP_MAGIC  (RP_MAGIC)
  ) u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_wrp       (wr_wrp),
    .wr_rdp       (wr_rdp),
    .wr_stat      (wr_stat),
    .wdata        (wdata),
    .ctrl_q       (regs[W_CTRL]),
    .stat_q       (stat_q),
    .irq_q        (irq),
    .arm_q        (arm_q),
    .complete_evt (complete_evt),
    .suppress_evt (suppress_evt),
    .clear_evt    (clear_evt)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    if (w == W_STAT) begin : g_stat
      assign regs[w] = stat_q;
    end else if (w == W_RDP) begin : g_rdp
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (wr_wrp) q <= wdata & PTR_WMASK;
      end
      assign regs[w] = q;
    end else begin : g_plain
      localparam logic [REG_W-1:0] MASK = store_mask(w, PTR_WMASK, CTRL_WMASK);
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= '0;
        else if (wr_store && int'(widx) == w) q <= wdata & MASK;
      end
      assign regs[w] = q;
    end
  end

  assign rdata = (rd_en && in_range) ? regs[widx] : '0;

  p_oor_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> ($stable(regs) && $stable(irq)))
    else $error("p_oor_stable_r2");

  p_rp_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wrp |=> (regs[W_RDP] == regs[W_WRP]))
    else $error("p_rp_mirror_r4");

  p_rp_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rdp |=> $stable(regs[W_RDP]))
    else $error("p_rp_kept_r5");

  p_arm_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress_evt || complete_evt) |-> $onehot0({suppress_evt, complete_evt, clear_evt}))
    else $error("p_arm_once_r6");

endmodule

// File: tb/tb_cmdq_reg_model.sv
`timescale 1ns/1ps
module tb_cmdq_reg_model;

  localparam logic [31:0] PTR_M = 32'h03FF_FFF8;
  localparam logic [31:0] CTRL_M = 32'h0173_03FF;
  localparam logic [31:0] MAGIC = 32'hEE88_2266;
  localparam logic [31:0] CMPL = 32'h0003_0000;
  localparam logic [31:0] SRST = 32'hF800_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] m [31];
  bit mflag;
  bit mirq;

  always #2.5 clk = ~clk;

  cmdq_reg_model #(.CTRL_WMASK(CTRL_M)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string tag_for(input int w);
    if (w == 6 || w == 7) return "R3";
    if (w == 8) return "R4";
    if (w == 14) return "R9";
    if (w == 15) return "R7";
    return "R11";
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 31; w++) m[w] = '0;
    m[15] = SRST;
    mflag = 0;
    mirq = 0;
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    int w;
    if (a >= 'h7C) return;
    w = a / 4;
    case (w)
      6: m[6] = d & PTR_M;
      7: begin
        m[7] = d & PTR_M;
        m[8] = m[7];
        if (mflag) mflag = 0;
        else begin
          m[15] = m[15] | CMPL;
          if ((m[14] & CMPL) != 0) mirq = 1;
        end
      end
      8: if (d == MAGIC) mflag = 1;
      14: m[14] = d & CTRL_M;
      15: if ((d & CMPL) != 0) begin
        m[15] = m[15] & ~CMPL;
        mirq = 0;
      end
      default: m[w] = d;
    endcase
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(int'(a), d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1;
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic check_all(input string force_tag);
    logic [31:0] v;
    for (int w = 0; w < 31; w++) begin
      do_read(8'(w * 4), v);
      check(force_tag != "" ? force_tag : tag_for(w), v, m[w]);
    end
    check(force_tag != "" ? force_tag : "R8", {31'd0, irq}, {31'd0, mirq});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all("R1");

    // R2: every out-of-range byte address, writes ignored and reads zero
    for (int a = 'h7C; a < 256; a++) do_write(8'(a), (a % 3 == 0) ? MAGIC : 32'hFFFF_FFFF);
    for (int a = 'h7C; a < 256; a += 4) begin
      do_read(8'(a), v);
      check("R2", v, 32'h0);
    end
    check_all("R2");

    // Sweep every in-range word twice, low address bits varied (R2), full readback
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 31; w++) begin
        do_write(8'(w * 4 + ((w + p) % 4)), 32'h9E37_79B9 * 32'(w + 1 + 31 * p));
        check_all("");
      end
    end

    // R9 control mask, R3 pointer mask
    do_write(8'h38, 32'hFFFF_FFFF);
    do_read(8'h38, v); check("R9", v, CTRL_M);
    do_write(8'h18, 32'hFFFF_FFFF);
    do_read(8'h18, v); check("R3", v, PTR_M);
    do_write(8'h3C, CMPL);
    check("R10", {31'd0, irq}, 32'd0);
    // R4 mirror
    do_write(8'h1C, 32'h0000_1000);
    do_read(8'h20, v); check("R4", v, 32'h0000_1000);
    do_write(8'h3C, CMPL);
    // R5 magic arms, read pointer untouched
    do_write(8'h20, MAGIC);
    do_read(8'h20, v); check("R5", v, 32'h0000_1000);
    do_write(8'h20, 32'h1234_5678);
    do_read(8'h20, v); check("R5", v, 32'h0000_1000);
    // R6 suppressed completion
    do_write(8'h1C, 32'h0000_2008);
    do_read(8'h20, v); check("R4", v, 32'h0000_2008);
    do_read(8'h3C, v); check("R6", v, SRST);
    check("R6", {31'd0, irq}, 32'd0);
    // next one completes: R7, R8
    do_write(8'h1C, 32'h0000_3010);
    do_read(8'h3C, v); check("R7", v, SRST | CMPL);
    check("R8", {31'd0, irq}, 32'd1);
    // R10 no-effect write, then clearing write
    do_write(8'h3C, 32'h0000_0001);
    check("R10", {31'd0, irq}, 32'd1);
    do_read(8'h3C, v); check("R10", v, SRST | CMPL);
    do_write(8'h3C, 32'h0002_0000);
    check("R10", {31'd0, irq}, 32'd0);
    do_read(8'h3C, v); check("R10", v, SRST);
    // R8 completion with interrupt disabled
    do_write(8'h38, 32'h0);
    do_write(8'h1C, 32'h0000_0040);
    do_read(8'h3C, v); check("R7", v, SRST | CMPL);
    check("R8", {31'd0, irq}, 32'd0);
    // R11 base address full width
    do_write(8'h14, 32'hDEAD_BEEF);
    do_read(8'h14, v); check("R11", v, 32'hDEAD_BEEF);
    check_all("");
    // R12 rd_en low gives zero, high gives same-cycle data
    addr = 8'h14; rd_en = 1'b0;
    #1; check("R12", rdata, 32'h0);
    rd_en = 1'b1;
    #1; check("R12", rdata, 32'hDEAD_BEEF);
    rd_en = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule